// File: doc/BRIEF.md
# Read-Latency Enable Delay Generator

This block sits in the receive side of a source-synchronous parallel interface. The core raises a read request for one clock cycle per word it expects back from the external device, so a request held for N cycles asks for N words. The block produces two delayed copies of that request train. The first copy is a strobe enable. It opens the gating window on the incoming strobe so that only edges carrying valid data reach the capture logic. The second copy is the read enable of the capture FIFO. A data-valid flag for the core comes out with it.

Both delays are fixed when the block is built. They are derived from one read-latency parameter, which is set to the latency of the external device. The strobe enable is delayed by exactly the read latency, which matches an output path with no extra write latency. The FIFO read enable is delayed by the read latency plus a capture margin of at least two cycles, which gives the captured word time to settle in the FIFO. A build option chooses the delay structure. One form cascades a single shift chain, tapping the strobe enable partway along it. The other form runs two independent chains side by side. Both forms give the same output timing.

Top module: `rle_enable_gen`

## Requirements
- R1: `strobe_en` is high in cycle c+RD_LAT exactly when `rd_req` was high in cycle c, and a reset has not occurred in any cycle from c onward.
- R2: `fifo_rd_en` is high in cycle c+RD_LAT+CAP_MARGIN exactly when `rd_req` was high in cycle c, and a reset has not occurred in any cycle from c onward.
- R3: `data_valid` is high in exactly the same cycles as `fifo_rd_en`.
- R4: The number of cycles with `data_valid` high equals the number of cycles with `rd_req` high. Back-to-back requests are neither merged nor dropped, and at most RD_LAT+CAP_MARGIN words are in flight at any time.
- R5: `rst` is a synchronous reset, active high. It clears every delay stage. From the cycle after a reset edge, all three outputs are low, and no request sampled at or before that edge ever produces an output.
- R6: For every word, `strobe_en` rises exactly CAP_MARGIN cycles before `fifo_rd_en` for that word. At no time are more than CAP_MARGIN strobe enables waiting for their read enable.
- R7: The build option SHARE_CHAIN=1 (one cascaded chain) and SHARE_CHAIN=0 (two parallel chains) give identical outputs for identical inputs.
- R8: The design supports the range RD_LAT=1 with CAP_MARGIN=2, at which the strobe enable follows the request by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Read request, high for one cycle per expected word |
| strobe_en | output | 1 | Strobe gating enable, request delayed by RD_LAT |
| fifo_rd_en | output | 1 | Capture FIFO read enable, request delayed by RD_LAT+CAP_MARGIN |
| data_valid | output | 1 | Word-valid flag to the core, cycle-aligned with fifo_rd_en |

## Verification
The bench drives three copies of the block from the same request and reset lines. Two copies use RD_LAT=5 and CAP_MARGIN=3, one with the cascaded chain and one with the parallel chains, so their outputs can be compared cycle by cycle. The third copy uses the smallest settings, RD_LAT=1 and CAP_MARGIN=2, in the parallel form. There the strobe tap is the very first stage, which exercises the single-stage chain case. The margin of 3 puts two stages between the taps, so a reset landing mid-flight cuts words that sit between the strobe tap and the read tap, as well as words still ahead of both.

// File: rtl/rle_pkg.sv
package rle_pkg;

  typedef struct packed {
    logic stb;
    logic rd;
  } rle_taps_t;

  // Strobe enable delay: read latency with no extra write latency added.
  function automatic int strobe_delay(input int rd_lat);
    return rd_lat;
  endfunction

  // FIFO read enable delay: strobe delay plus the capture margin.
  function automatic int read_delay(input int rd_lat, input int margin);
    return strobe_delay(rd_lat) + margin;
  endfunction

endpackage

// File: rtl/rle_delay_line.sv
module rle_delay_line #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stage_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/rle_out_stage.sv
module rle_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic tap_i,
  output logic rd_en_o,
  output logic valid_o
);
  always_ff @(posedge clk) begin
    if (rst) rd_en_o <= 1'b0;
    else     rd_en_o <= tap_i;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= tap_i;
  end
endmodule

// File: rtl/rle_enable_gen.sv
module rle_enable_gen #(
  parameter int RD_LAT      = 5,
  parameter int CAP_MARGIN  = 3,
  parameter bit SHARE_CHAIN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  output logic strobe_en,
  output logic fifo_rd_en,
  output logic data_valid
);
  import rle_pkg::*;

  localparam int STB_DLY = strobe_delay(RD_LAT);
  localparam int RD_DLY  = read_delay(RD_LAT, CAP_MARGIN);
  // The output stage adds one register, so the chain feeding it is one shorter.
  localparam int RD_CHAIN = RD_DLY - 1;
  localparam int GAP      = RD_CHAIN - STB_DLY;

  rle_taps_t taps;
  logic      stb_tap;
  logic      rd_tap;

  generate
    if (SHARE_CHAIN) begin : g_cascade
      rle_delay_line #(.DEPTH(STB_DLY)) u_head (
        .clk(clk), .rst(rst), .din(rd_req), .dout(stb_tap)
      );
      rle_delay_line #(.DEPTH(GAP)) u_tail (
        .clk(clk), .rst(rst), .din(stb_tap), .dout(rd_tap)
      );
    end else begin : g_parallel
      rle_delay_line #(.DEPTH(STB_DLY)) u_stb (
        .clk(clk), .rst(rst), .din(rd_req), .dout(stb_tap)
      );
      rle_delay_line #(.DEPTH(RD_CHAIN)) u_rd (
        .clk(clk), .rst(rst), .din(rd_req), .dout(rd_tap)
      );
    end
  endgenerate

  assign taps.stb = stb_tap;
  assign taps.rd  = rd_tap;

  rle_out_stage u_out (
    .clk(clk), .rst(rst), .tap_i(taps.rd),
    .rd_en_o(fifo_rd_en), .valid_o(data_valid)
  );

  assign strobe_en = taps.stb;
endmodule

// File: rtl/rle_enable_gen_chk.sv
module rle_enable_gen_chk #(
  parameter int RD_LAT     = 5,
  parameter int CAP_MARGIN = 3
) (
  input logic clk,
  input logic rst,
  input logic rd_req,
  input logic strobe_en,
  input logic fifo_rd_en,
  input logic data_valid
);
  localparam int RD_DLY = rle_pkg::read_delay(RD_LAT, CAP_MARGIN);
  localparam int CW     = $clog2(RD_DLY + 2) + 1;

  logic [CW-1:0] inflight;
  logic [CW-1:0] stb_lead;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= '0;
      stb_lead <= '0;
    end else begin
      inflight <= inflight + CW'(rd_req) - CW'(data_valid);
      stb_lead <= stb_lead + CW'(strobe_en) - CW'(fifo_rd_en);
    end
  end

  p_reset_clears_r5: assert property (@(posedge clk)
    rst |=> (!strobe_en && !fifo_rd_en && !data_valid));

  p_valid_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    data_valid == fifo_rd_en);

  p_no_orphan_valid_r4: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (inflight != '0));

  p_inflight_bound_r4: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(RD_DLY));

  p_strobe_leads_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_en |-> (stb_lead != '0));

  p_lead_bound_r6: assert property (@(posedge clk) disable iff (rst)
    stb_lead <= CW'(CAP_MARGIN));
endmodule

bind rle_enable_gen rle_enable_gen_chk #(
  .RD_LAT(RD_LAT), .CAP_MARGIN(CAP_MARGIN)
) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req),
  .strobe_en(strobe_en), .fifo_rd_en(fifo_rd_en), .data_valid(data_valid)
);

// File: tb/rle_enable_gen_tb.sv
`timescale 1ns/1ps
module rle_enable_gen_tb;
  localparam int A_LAT = 5, A_MAR = 3;
  localparam int M_LAT = 1, M_MAR = 2;
  localparam int NPAT  = 7;
  localparam logic [15:0] PATS [NPAT] = '{
    16'h0001, 16'h8001, 16'hAAAA, 16'hFFFF, 16'hF0F0, 16'h1248, 16'hCCCC
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req = 1'b0;
  logic a_stb, a_rd, a_vld, s_stb, s_rd, s_vld, m_stb, m_rd, m_vld;

  always #5 clk = ~clk;

  rle_enable_gen #(.RD_LAT(A_LAT), .CAP_MARGIN(A_MAR), .SHARE_CHAIN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .rd_req(rd_req),
    .strobe_en(a_stb), .fifo_rd_en(a_rd), .data_valid(a_vld));
  rle_enable_gen #(.RD_LAT(A_LAT), .CAP_MARGIN(A_MAR), .SHARE_CHAIN(1'b0)) u_dut_split (
    .clk(clk), .rst(rst), .rd_req(rd_req),
    .strobe_en(s_stb), .fifo_rd_en(s_rd), .data_valid(s_vld));
  rle_enable_gen #(.RD_LAT(M_LAT), .CAP_MARGIN(M_MAR), .SHARE_CHAIN(1'b0)) u_dut_min (
    .clk(clk), .rst(rst), .rd_req(rd_req),
    .strobe_en(m_stb), .fifo_rd_en(m_rd), .data_valid(m_vld));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rst_last = -1;
  bit hist [0:4095];
  int req_cnt = 0, a_vld_cnt = 0, m_vld_cnt = 0;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected enable: the request d cycles back, unless a reset came since.
  function automatic logic expect_at(input int d);
    if (cyc < d) return 1'b0;
    if (cyc - d <= rst_last) return 1'b0;
    return hist[cyc - d];
  endfunction

  task automatic step(input bit req_v, input bit rst_v);
    @(negedge clk);
    check("R1 strobe u_dut", a_stb, expect_at(A_LAT));
    check("R2 rd_en u_dut", a_rd, expect_at(A_LAT + A_MAR));
    check("R3 valid u_dut", a_vld, expect_at(A_LAT + A_MAR));
    check("R7 strobe split", s_stb, a_stb);
    check("R7 rd_en split", s_rd, a_rd);
    check("R7 valid split", s_vld, a_vld);
    check("R8 strobe min", m_stb, expect_at(M_LAT));
    check("R8 rd_en min", m_rd, expect_at(M_LAT + M_MAR));
    check("R3 valid min", m_vld, expect_at(M_LAT + M_MAR));
    if (a_vld === 1'b1) a_vld_cnt++;
    if (m_vld === 1'b1) m_vld_cnt++;
    rd_req = req_v;
    rst = rst_v;
    hist[cyc] = req_v;
    if (rst_v) rst_last = cyc;
    else if (req_v) req_cnt++;
    cyc++;
  endtask

  task automatic clear_counts();
    req_cnt = 0; a_vld_cnt = 0; m_vld_cnt = 0;
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    // R5: outputs held low while reset is asserted, even with requests.
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
    check("R5 reset state strobe", a_stb, 1'b0);
    check("R5 reset state valid", a_vld, 1'b0);

    // Table-driven patterns, each followed by a drain window.
    for (int p = 0; p < NPAT; p++) begin
      clear_counts();
      for (int b = 0; b < 16; b++) step(PATS[p][b], 1'b0);
      for (int b = 0; b < 16; b++) step(1'b0, 1'b0);
      check_int("R4 valid count u_dut", a_vld_cnt, req_cnt);
      check_int("R4 valid count min", m_vld_cnt, req_cnt);
    end

    // R4: long back-to-back burst, no gaps merged or dropped.
    clear_counts();
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0);
    check_int("R4 burst count u_dut", a_vld_cnt, 40);
    check_int("R4 burst count min", m_vld_cnt, 40);

    // R5: reset mid-flight leaves no stale enables afterwards.
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    clear_counts();
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0);
    check_int("R5 stale valids u_dut", a_vld_cnt, 0);
    check_int("R5 stale valids min", m_vld_cnt, 0);

    // Isolated single word after reset still arrives on time.
    clear_counts();
    step(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
    check_int("R1 single word after reset", a_vld_cnt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule